// File: doc/BRIEF.md
# Serial ADC Command Framer

This block is the device-side serial front end of a multichannel 12-bit converter. It runs on a fast system clock and watches an active-low chip select, a serial clock and a serial data input, all synchronous to the system clock. Framing is not tied to chip select. With chip select low and the framer waiting, the first `1` sampled on a rising serial-clock edge is taken as the start bit. That bit also becomes the most significant bit of an 8-bit command. On the first falling serial-clock edge after the eighth command bit, the framer presents the command on a parallel output with a one-cycle start pulse. It also drops a status strobe.

The analog conversion itself lives outside this block. It reports back through a done pulse and a 12-bit result. The framer then raises the strobe and shifts the result out MSB first, one bit per falling serial-clock edge, with zeros after the LSB. A new start bit is accepted during readout only once result bit 5 has been driven, so back-to-back frames take 15 serial clocks. A `1` that arrives while the conversion is still running abandons it and opens a new command. A long run of zeros while converting returns the framer to its waiting state.

Top module: `adc_cmd_framer`

## Requirements
- R1: After reset the strobe is high, the start pulse is low, data-out is 0, and the data-out enable equals the inverse of chip select.
- R2: A falling chip select and any zeros sampled while waiting start nothing. The first 1 sampled on a rising serial-clock edge with chip select low is the start bit and becomes bit 7 of the captured command.
- R3: The start pulse lasts one system clock and follows the falling serial-clock edge after the eighth command bit. The command output changes only with that pulse, and the strobe goes low with it.
- R4: A done pulse during a conversion loads the result and raises the strobe. Each later falling serial-clock edge with chip select low drives the next result bit on data-out, bit 11 first, then zeros after bit 0.
- R5: Before any result has been loaded, data-out shifts only zeros.
- R6: During readout, a 1 on data-in is ignored until seven result bits (bits 11 down to 5) have been driven. After that it is a start bit, which gives a 15-clock frame.
- R7: A 1 on data-in while a conversion is running abandons it, raises the strobe and opens a new command. A done pulse when no conversion is running has no effect.
- R8: During a conversion, 16 consecutive zeros sampled with chip select low abandon it and raise the strobe. The next 1 is then a start bit.
- R9: Chip select high drops the data-out enable and discards a partly captured command. A conversion already started stays pending, and its result can be read after chip select returns low.
- R10: Serial-clock edges are ignored while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial data in |
| conv_done | input | 1 | One-cycle pulse when the conversion is complete |
| conv_result | input | 12 | Conversion result, valid with conv_done |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Data-out enable (high while selected) |
| sstrb | output | 1 | Status strobe, low while converting |
| ctrl_byte | output | 8 | Last command that started a conversion |
| conv_start | output | 1 | One-cycle conversion-start pulse |

## Verification
The assertions assume that serial clock, chip select and data-in are synchronous to the system clock. They also assume that each serial-clock level is held for several system clocks, so that every edge is seen once, and that conv_done is a single-cycle pulse. The bench drives every input on the falling system-clock edge. It holds each serial-clock phase for four system clocks and changes chip select only while the serial clock is low. It raises conv_done for exactly one cycle.

// File: rtl/adc_cmd_framer.sv
module adc_cmd_framer #(
  parameter int CMD_W      = 8,
  parameter int DATA_W     = 12,
  parameter int OPEN_AFTER = 7,
  parameter int SYNC_ZEROS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              dout,
  output logic              dout_oe,
  output logic              sstrb,
  output logic [CMD_W-1:0]  ctrl_byte,
  output logic              conv_start
);
  localparam int BW = $clog2(CMD_W);
  localparam int SW = $clog2(DATA_W + 1);
  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam logic [CMD_W-1:0] FIRST = CMD_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_CAPT, S_ARMED, S_CONV, S_SHIFT} st_t;

  st_t               st;
  logic              sclk_q;
  logic [BW-1:0]     bcnt;
  logic [CMD_W-1:0]  cbuf;
  logic [DATA_W-1:0] shreg;
  logic [SW-1:0]     scnt;
  logic [ZW-1:0]     zrun;

  wire rise = sclk & ~sclk_q;
  wire fall = ~sclk & sclk_q;
  wire open_rd = scnt >= SW'(OPEN_AFTER);

  assign dout_oe = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      sclk_q     <= 1'b0;
      bcnt       <= '0;
      cbuf       <= '0;
      shreg      <= '0;
      scnt       <= '0;
      zrun       <= '0;
      dout       <= 1'b0;
      sstrb      <= 1'b1;
      ctrl_byte  <= '0;
      conv_start <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      conv_start <= 1'b0;
      if (cs_n) begin
        zrun <= '0;
        if (st == S_CAPT || st == S_ARMED) st <= S_IDLE;
      end else begin
        if (rise) begin
          if (din) zrun <= '0;
          else if (zrun != ZW'(SYNC_ZEROS)) zrun <= zrun + 1'b1;
          case (st)
            S_IDLE: if (din) begin
              cbuf <= FIRST; bcnt <= BW'(1); st <= S_CAPT;
            end
            S_CAPT: begin
              cbuf <= {cbuf[CMD_W-2:0], din};
              bcnt <= bcnt + 1'b1;
              if (bcnt == BW'(CMD_W - 1)) st <= S_ARMED;
            end
            S_CONV: if (din) begin
              cbuf <= FIRST; bcnt <= BW'(1); st <= S_CAPT; sstrb <= 1'b1;
            end else if (zrun == ZW'(SYNC_ZEROS - 1)) begin
              st <= S_IDLE; sstrb <= 1'b1;
            end
            S_SHIFT: if (din && open_rd) begin
              cbuf <= FIRST; bcnt <= BW'(1); st <= S_CAPT;
            end
            default: ;
          endcase
        end
        if (fall) begin
          dout  <= shreg[DATA_W-1];
          shreg <= shreg << 1;
          if (scnt != SW'(DATA_W)) scnt <= scnt + 1'b1;
          if (st == S_ARMED) begin
            st <= S_CONV; ctrl_byte <= cbuf; conv_start <= 1'b1; sstrb <= 1'b0;
          end
        end
      end
      if (conv_done && st == S_CONV) begin
        shreg <= conv_result;
        scnt  <= '0;
        st    <= S_SHIFT;
        sstrb <= 1'b1;
      end
    end
  end

  a_r3_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(fall && !cs_n));
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r3_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_byte) |-> conv_start);
  a_r3_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sstrb) |-> conv_start);
  a_r2_start_msb: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ctrl_byte[CMD_W-1]);
  a_r4_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(fall && !cs_n));
  a_r4_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> ($past(conv_done) || $past(rise && !cs_n)));
endmodule

// File: tb/adc_cmd_framer_tb.sv
module adc_cmd_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic        dout, dout_oe, sstrb, conv_start;
  logic [7:0]  ctrl_byte;

  int total = 0;
  int bad = 0;
  int n_start = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_done(conv_done), .conv_result(conv_result), .dout(dout),
    .dout_oe(dout_oe), .sstrb(sstrb), .ctrl_byte(ctrl_byte), .conv_start(conv_start)
  );

  always @(posedge clk) if (conv_start) n_start <= n_start + 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic d);
    @(negedge clk) din = b;
    @(negedge clk) sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    d = dout;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) bit_io(v[i], d);
  endtask

  task automatic pulse_done(input logic [11:0] r);
    @(negedge clk) begin conv_result = r; conv_done = 1'b1; end
    @(negedge clk) conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 strobe", sstrb, 1);
    chk("R1 start", conv_start, 0);
    chk("R1 dout", dout, 0);
    chk("R1 oe off", dout_oe, 0);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    chk("R1 oe on", dout_oe, 1);
  endtask

  task automatic t_idle;
    logic d;
    int s0 = n_start;
    pulse_done(12'hFFF);
    for (int i = 0; i < 5; i++) begin
      bit_io(1'b0, d);
      chk("R5 zeros before result", d, 0);
    end
    chk("R2 no start on zeros", n_start, s0);
    chk("R7 stray done ignored", sstrb, 1);
  endtask

  task automatic t_frame;
    int s0 = n_start;
    send_byte(8'hB3);
    chk("R3 one start", n_start, s0 + 1);
    chk("R2 byte", ctrl_byte, 8'hB3);
    chk("R3 strobe low", sstrb, 0);
  endtask

  task automatic t_read;
    logic d;
    logic [11:0] r = 12'hA5C;
    int s0 = n_start;
    pulse_done(r);
    chk("R4 strobe high", sstrb, 1);
    for (int k = 0; k < 16; k++) begin
      bit_io(1'b0, d);
      chk("R4 result bit", d, (k < 12) ? r[11-k] : 0);
    end
    chk("R4 no start", n_start, s0);
  endtask

  task automatic t_early;
    logic d;
    logic [11:0] r = 12'h3E7;
    logic [7:0] nb = 8'hD4;
    int s0;
    send_byte(8'hC1);
    s0 = n_start;
    pulse_done(r);
    for (int k = 0; k < 7; k++) begin
      bit_io(1'b1, d);
      chk("R6 bit before open", d, r[11-k]);
    end
    chk("R6 ones ignored", n_start, s0);
    for (int k = 7; k >= 0; k--) begin
      bit_io(nb[k], d);
      if (k >= 3) chk("R6 tail bits", d, r[k-3]);
    end
    chk("R6 15-clock start", n_start, s0 + 1);
    chk("R6 byte", ctrl_byte, nb);
  endtask

  task automatic t_abort;
    logic d;
    int s0 = n_start;
    chk("R7 converting", sstrb, 0);
    bit_io(1'b1, d);
    chk("R7 abandon strobe", sstrb, 1);
    for (int k = 6; k >= 0; k--) bit_io(1'(8'h8F >> k), d);
    chk("R7 restart", n_start, s0 + 1);
    chk("R7 byte", ctrl_byte, 8'h8F);
  endtask

  task automatic t_zeros;
    logic d;
    int s0;
    for (int k = 0; k < 15; k++) bit_io(1'b0, d);
    chk("R8 15 zeros keep", sstrb, 0);
    bit_io(1'b0, d);
    chk("R8 16 zeros release", sstrb, 1);
    pulse_done(12'h123);
    for (int k = 0; k < 12; k++) begin
      bit_io(1'b0, d);
      chk("R7 done ignored dout", d, 0);
    end
    s0 = n_start;
    send_byte(8'hA0);
    chk("R8 start after sync", n_start, s0 + 1);
    chk("R8 byte", ctrl_byte, 8'hA0);
  endtask

  task automatic t_cs;
    logic d;
    logic [11:0] r = 12'h9C3;
    int s0 = n_start;
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R9 oe off", dout_oe, 0);
    chk("R9 pending", sstrb, 0);
    pulse_done(r);
    chk("R9 done while deselected", sstrb, 1);
    for (int k = 0; k < 8; k++) bit_io(1'b1, d);
    chk("R10 no start deselected", n_start, s0);
    @(negedge clk) cs_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bit_io(1'b0, d);
      chk("R10 read after reselect", d, r[11-k]);
    end
    bit_io(1'b1, d);
    bit_io(1'b0, d);
    bit_io(1'b1, d);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    send_byte(8'h96);
    chk("R9 partial discarded", n_start, s0 + 1);
    chk("R9 byte", ctrl_byte, 8'h96);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_frame();
    t_read();
    t_early();
    t_abort();
    t_zeros();
    t_cs();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule